// File: doc/BRIEF.md
# Zig-Zag Run/Size Coefficient Coder

This block turns one 8x8 block of quantized, signed transform coefficients into the symbol stream that an entropy coder feeds into its Huffman tables. Software or an upstream engine fills a 64-entry coefficient buffer through a simple write port, using raster addressing, and then pulses `start`. The coder walks the buffer along the anti-diagonal zig-zag path. It sends the first coefficient as a size category with its raw bits. Every later nonzero coefficient goes out as a run/size byte with its raw bits.

Zero runs longer than fifteen are broken up with extension symbols. Once no nonzero coefficient remains, one end-of-block symbol closes the stream. Each symbol travels as one beat on a valid/ready stream. The beat carries the symbol byte, the raw-bit count and the raw bits, right-aligned. A one-cycle `done` pulse marks the end of the block. Huffman lookup, DC prediction and bit packing belong to the stages that follow.

Top module: `zz_runsize_coder`

## Requirements
- R1: A write with `coef_we` high stores `coef_wdata` at raster address `coef_addr` = row*8+col. The scan visits zig-zag index k along anti-diagonals: k0=(r0,c0), k1=(r0,c1), k2=(r1,c0), k3=(r2,c0), k4=(r1,c1), k5=(r0,c2). Odd diagonals are walked with the row rising and even diagonals with the row falling.
- R2: The first beat of every block carries the k0 coefficient. Its `sym_code` is {4'h0, category} and its `sym_nbits` equals the category. For example, 22 gives code 8'h05 with raw bits 10110.
- R3: The category of a value is zero for zero. Otherwise it is one plus the bit position of the highest set bit of the absolute value, so it is at most 11 over the supported range -2047..2047.
- R4: Raw bits sit right-aligned in `sym_bits` with `sym_nbits` bits used and all upper bits zero. A positive value sends its own low bits. A negative value sends the bitwise complement of its magnitude, so -12 gives 0011 and -8 gives 0111.
- R5: Each nonzero coefficient at k>=1 gives one beat with `sym_code` = {zeros since the previous emitted symbol, category} and `sym_nbits` = category.
- R6: When sixteen zeros have gone by and a nonzero coefficient still follows later, the coder sends `sym_code` 8'hF0 with `sym_nbits` 0 and restarts the run count.
- R7: At the first zero at k>=1 with no nonzero coefficient after it, the coder sends `sym_code` 8'h00 with `sym_nbits` 0, and that is the last beat. If the k63 coefficient is nonzero, no 8'h00 beat follows its symbol.
- R8: While `sym_valid` is high and `sym_ready` is low, `sym_valid`, `sym_code`, `sym_nbits` and `sym_bits` hold their values.
- R9: `done` is high for exactly the one cycle after the handshake of the final beat. It is never high together with `sym_valid`, and it is never high at any other time.
- R10: A `start` pulse while a block is still in progress is ignored, and the symbol stream of that block is unchanged.
- R11: The first beat is valid on the second rising edge after the edge that samples `start`. With `sym_ready` held high, the coder processes one coefficient per cycle.
- R12: After reset, `sym_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Coefficient buffer write strobe |
| coef_addr | input | 6 | Raster address, row*8+col |
| coef_wdata | input | 12 | Signed coefficient to store |
| start | input | 1 | Pulse that begins coding the stored block |
| sym_valid | output | 1 | Output beat is valid |
| sym_ready | input | 1 | Downstream accepts the beat |
| sym_code | output | 8 | Run/size byte, DC category, 8'hF0 or 8'h00 |
| sym_nbits | output | 4 | Number of raw bits used |
| sym_bits | output | 11 | Raw bits, right-aligned |
| done | output | 1 | One-cycle pulse after the final beat is taken |

## Verification
The first beat must appear on the second edge after `start` is sampled. Each beat is due at the edge after the previous one is taken, or later by one cycle for every zero that does not end a run. `done` is due on the edge right after the final handshake. The bench changes inputs and reads outputs only on falling edges. A beat counts as taken when `sym_valid` is high at the falling edge where the bench raises `sym_ready`. The bench checks the start-to-first-beat distance as exactly two, and checks `done` on the falling edge after the final handshake. It compares every taken beat in order with a list built from its own zig-zag walk and symbol model, so the check does not depend on how many cycles the run counting takes.

// File: rtl/zz_coder_pkg.sv
package zz_coder_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DC,
    ST_AC,
    ST_FLUSH
  } scan_state_e;

  localparam logic [7:0] SYM_ZRL = 8'hF0;
  localparam logic [7:0] SYM_EOB = 8'h00;
  localparam int RUN_W = 4;
  localparam int CAT_W = 4;

  // Raster position (row*n+col) of zig-zag index k on an n x n block.
  function automatic int zz_to_raster(input int k, input int n);
    int cnt;
    int r_lo;
    int r_hi;
    int len;
    int row;
    cnt = 0;
    zz_to_raster = 0;
    for (int s = 0; s < 2 * n - 1; s++) begin
      r_lo = (s - n + 1 > 0) ? s - n + 1 : 0;
      r_hi = (s < n - 1) ? s : n - 1;
      len  = r_hi - r_lo + 1;
      if (k >= cnt && k < cnt + len) begin
        row = (s % 2 == 1) ? r_lo + (k - cnt) : r_hi - (k - cnt);
        zz_to_raster = row * n + (s - row);
      end
      cnt = cnt + len;
    end
  endfunction

endpackage

// File: rtl/zz_coef_buf.sv
module zz_coef_buf #(
  parameter int N      = 8,
  parameter int COEF_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(N*N)-1:0]        wr_addr,
  input  logic [COEF_W-1:0]             wr_data,
  input  logic [$clog2(N*N)-1:0]        rd_idx,
  output logic [COEF_W-1:0]             rd_data,
  output logic                          nz_after
);
  import zz_coder_pkg::*;

  localparam int NCOEF = N * N;

  logic [COEF_W-1:0] mem_q   [NCOEF];
  logic [COEF_W-1:0] zz_coef [NCOEF];
  logic [NCOEF-1:0]  nz_zz;

  for (genvar a = 0; a < NCOEF; a++) begin : g_store
    logic hit;
    assign hit = wr_en && (int'(wr_addr) == a);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[a] <= '0;
      end else if (hit) begin
        mem_q[a] <= wr_data;
      end
    end
  end

  for (genvar k = 0; k < NCOEF; k++) begin : g_zz
    localparam int RK = zz_to_raster(k, N);
    assign zz_coef[k] = mem_q[RK];
    assign nz_zz[k]   = |mem_q[RK];
  end

  assign rd_data = zz_coef[rd_idx];

  always_comb begin
    nz_after = 1'b0;
    for (int j = 0; j < NCOEF; j++) begin
      if (j > int'(rd_idx) && nz_zz[j]) nz_after = 1'b1;
    end
  end

endmodule

// File: rtl/zz_size_cat.sv
module zz_size_cat #(
  parameter int COEF_W = 12
) (
  input  logic [COEF_W-1:0]           coef,
  output logic [zz_coder_pkg::CAT_W-1:0] cat,
  output logic [COEF_W-2:0]           raw
);
  import zz_coder_pkg::*;

  localparam int RAW_W = COEF_W - 1;

  logic              neg;
  logic [COEF_W-1:0] mag;
  logic [COEF_W-1:0] pattern;

  always_comb begin
    neg     = coef[COEF_W-1];
    mag     = neg ? (~coef + 1'b1) : coef;
    pattern = neg ? (coef - 1'b1) : coef;
    cat     = '0;
    for (int b = 0; b < RAW_W; b++) begin
      if (mag[b]) cat = CAT_W'(b + 1);
    end
    raw = '0;
    for (int b = 0; b < RAW_W; b++) begin
      raw[b] = pattern[b] && (b < int'(cat));
    end
  end

endmodule

// File: rtl/zz_scan_fsm.sv
module zz_scan_fsm #(
  parameter int N      = 8,
  parameter int COEF_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          coef_nz,
  input  logic [zz_coder_pkg::CAT_W-1:0] coef_cat,
  input  logic [COEF_W-2:0]             coef_raw,
  input  logic                          nz_after,
  output logic [$clog2(N*N)-1:0]        rd_idx,
  output logic                          sym_valid,
  input  logic                          sym_ready,
  output logic [7:0]                    sym_code,
  output logic [zz_coder_pkg::CAT_W-1:0] sym_nbits,
  output logic [COEF_W-2:0]             sym_bits,
  output logic                          done
);
  import zz_coder_pkg::*;

  localparam int IDX_W = $clog2(N * N);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N * N - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = '1;

  scan_state_e       state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic              valid_q, valid_d;
  logic [7:0]        code_q, code_d;
  logic [CAT_W-1:0]  nbits_q, nbits_d;
  logic [COEF_W-2:0] bits_q, bits_d;
  logic              done_q, done_d;
  logic              slot_free;
  logic              load_en;

  assign slot_free = !valid_q || sym_ready;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    run_d   = run_q;
    valid_d = valid_q && !sym_ready;
    code_d  = code_q;
    nbits_d = nbits_q;
    bits_d  = bits_q;
    done_d  = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_DC;
          idx_d   = '0;
          run_d   = '0;
        end
      end
      ST_DC: begin
        if (slot_free) begin
          load_en = 1'b1;
          code_d  = {4'h0, coef_cat};
          nbits_d = coef_cat;
          bits_d  = coef_raw;
          idx_d   = idx_q + 1'b1;
          state_d = ST_AC;
        end
      end
      ST_AC: begin
        if (slot_free) begin
          if (coef_nz) begin
            load_en = 1'b1;
            code_d  = {run_q, coef_cat};
            nbits_d = coef_cat;
            bits_d  = coef_raw;
            run_d   = '0;
            if (idx_q == LAST_IDX) state_d = ST_FLUSH;
            else                   idx_d   = idx_q + 1'b1;
          end else if (!nz_after) begin
            load_en = 1'b1;
            code_d  = SYM_EOB;
            nbits_d = '0;
            bits_d  = '0;
            state_d = ST_FLUSH;
          end else if (run_q == RUN_MAX) begin
            load_en = 1'b1;
            code_d  = SYM_ZRL;
            nbits_d = '0;
            bits_d  = '0;
            run_d   = '0;
            idx_d   = idx_q + 1'b1;
          end else begin
            run_d = run_q + 1'b1;
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_FLUSH: begin
        if (valid_q && sym_ready) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (load_en) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      run_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      run_q   <= run_d;
      valid_q <= valid_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      nbits_q <= '0;
      bits_q  <= '0;
    end else if (load_en) begin
      code_q  <= code_d;
      nbits_q <= nbits_d;
      bits_q  <= bits_d;
    end
  end

  assign rd_idx    = idx_q;
  assign sym_valid = valid_q;
  assign sym_code  = code_q;
  assign sym_nbits = nbits_q;
  assign sym_bits  = bits_q;
  assign done      = done_q;

  // R8
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable({sym_code, sym_nbits, sym_bits})));

  // R9
  done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(sym_valid && sym_ready));

  // R9
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, sym_valid}));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start) |=> (state_q != ST_DC));

  // R2
  dc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DC && slot_free) |=> (sym_valid && sym_code[7:4] == 4'h0));

  // R6
  zrl_nobits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && state_q == ST_AC && sym_code == SYM_ZRL) |-> (sym_nbits == '0 && sym_bits == '0));

endmodule

// File: rtl/zz_runsize_coder.sv
module zz_runsize_coder #(
  parameter int N      = 8,
  parameter int COEF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     coef_we,
  input  logic [$clog2(N*N)-1:0]   coef_addr,
  input  logic [COEF_W-1:0]        coef_wdata,
  input  logic                     start,
  output logic                     sym_valid,
  input  logic                     sym_ready,
  output logic [7:0]               sym_code,
  output logic [3:0]               sym_nbits,
  output logic [COEF_W-2:0]        sym_bits,
  output logic                     done
);
  import zz_coder_pkg::*;

  localparam int IDX_W = $clog2(N * N);

  logic [IDX_W-1:0]  rd_idx;
  logic [COEF_W-1:0] rd_coef;
  logic              nz_after;
  logic [CAT_W-1:0]  cat;
  logic [COEF_W-2:0] raw;

  zz_coef_buf #(.N(N), .COEF_W(COEF_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (coef_we),
    .wr_addr  (coef_addr),
    .wr_data  (coef_wdata),
    .rd_idx   (rd_idx),
    .rd_data  (rd_coef),
    .nz_after (nz_after)
  );

  zz_size_cat #(.COEF_W(COEF_W)) u_cat (
    .coef (rd_coef),
    .cat  (cat),
    .raw  (raw)
  );

  zz_scan_fsm #(.N(N), .COEF_W(COEF_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .coef_nz   (|rd_coef),
    .coef_cat  (cat),
    .coef_raw  (raw),
    .nz_after  (nz_after),
    .rd_idx    (rd_idx),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .sym_code  (sym_code),
    .sym_nbits (sym_nbits),
    .sym_bits  (sym_bits),
    .done      (done)
  );

endmodule

// File: tb/zz_runsize_coder_test.sv
module zz_runsize_coder_test;

  logic        clk;
  logic        rst_n;
  logic        coef_we;
  logic [5:0]  coef_addr;
  logic [11:0] coef_wdata;
  logic        start;
  logic        sym_valid;
  logic        sym_ready;
  logic [7:0]  sym_code;
  logic [3:0]  sym_nbits;
  logic [10:0] sym_bits;
  logic        done;

  int n_cmp;
  int n_bad;
  int cyc;

  int zz_r [64];
  int zz_c [64];
  int blk  [64];          // raster-ordered block to load
  int e_code [128];
  int e_nb   [128];
  int e_bits [128];
  int n_exp;

  zz_runsize_coder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .coef_we    (coef_we),
    .coef_addr  (coef_addr),
    .coef_wdata (coef_wdata),
    .start      (start),
    .sym_valid  (sym_valid),
    .sym_ready  (sym_ready),
    .sym_code   (sym_code),
    .sym_nbits  (sym_nbits),
    .sym_bits   (sym_bits),
    .done       (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Zig-zag walk by stepping across the block.
  task automatic build_zz();
    int r = 0;
    int c = 0;
    for (int k = 0; k < 64; k++) begin
      zz_r[k] = r;
      zz_c[k] = c;
      if ((r + c) % 2 == 0) begin
        if (c == 7) r++;
        else if (r == 0) c++;
        else begin r--; c++; end
      end else begin
        if (r == 7) c++;
        else if (c == 0) r++;
        else begin r++; c--; end
      end
    end
  endtask

  function automatic int size_of(input int v);
    int m = (v < 0) ? -v : v;
    int s = 0;
    while (m > 0) begin s++; m = m >> 1; end
    return s;
  endfunction

  function automatic int raw_of(input int v);
    int s = size_of(v);
    int mask = (1 << s) - 1;
    return (v < 0) ? ((~(-v)) & mask) : (v & mask);
  endfunction

  task automatic push(input int code, input int nb, input int bits);
    e_code[n_exp] = code;
    e_nb[n_exp]   = nb;
    e_bits[n_exp] = bits;
    n_exp++;
  endtask

  task automatic model();
    int zz [64];
    int last = 0;
    int run = 0;
    n_exp = 0;
    for (int k = 0; k < 64; k++) zz[k] = blk[zz_r[k] * 8 + zz_c[k]];
    for (int k = 1; k < 64; k++) if (zz[k] != 0) last = k;
    push(size_of(zz[0]), size_of(zz[0]), raw_of(zz[0]));
    for (int k = 1; k < 64; k++) begin
      if (k > last) begin
        push(8'h00, 0, 0);
        break;
      end
      if (zz[k] != 0) begin
        push(run * 16 + size_of(zz[k]), size_of(zz[k]), raw_of(zz[k]));
        run = 0;
      end else if (run == 15) begin
        push(8'hF0, 0, 0);
        run = 0;
      end else begin
        run++;
      end
    end
  endtask

  function automatic string tag_of(input int i, input int code);
    if (i == 0) return "R2";
    if (code == 8'hF0) return "R6";
    if (code == 8'h00) return "R7";
    return "R5";
  endfunction

  task automatic set_zz(input int k, input int v);
    blk[zz_r[k] * 8 + zz_c[k]] = v;
  endtask

  task automatic clear_blk();
    for (int i = 0; i < 64; i++) blk[i] = 0;
  endtask

  task automatic rand_blk(input int density);
    for (int i = 0; i < 64; i++) begin
      int w = 1 + ($urandom % 11);
      int m = $urandom & ((1 << w) - 1);
      if (m == 0) m = 1;
      blk[i] = (($urandom % 100) < density) ? (($urandom % 2) ? -m : m) : 0;
    end
  endtask

  task automatic run_block(input int stall, input bit poke, input bit time_chk);
    int got = 0;
    int it = 0;
    int first_it = -1;
    bit pend_done = 0;
    bit done_seen = 0;
    bit stray = 0;
    bit held = 0;
    int held_val = 0;
    int beat;
    bit rdy;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      coef_we    = 1'b1;
      coef_addr  = 6'(i);
      coef_wdata = 12'(blk[i]);
    end
    @(negedge clk);
    coef_we = 1'b0;
    model();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done_seen && it < 3000) begin
      beat = {sym_code, sym_nbits, sym_bits};
      if (held) begin
        // R8: a stalled beat is still offered unchanged
        chk(sym_valid && beat == held_val, "R8", "stalled beat", beat, held_val);
        held = 0;
      end
      if (pend_done) begin
        chk(done == 1'b1, "R9", "done after final take", done, 1);
        chk(sym_valid == 1'b0, "R9", "valid with done", sym_valid, 0);
        done_seen = 1;
      end else begin
        if (done) stray = 1;
        rdy = (($urandom % 100) >= stall);
        sym_ready = rdy;
        start = (poke && it == 5);
        if (sym_valid && first_it < 0) first_it = it;
        if (sym_valid && rdy) begin
          if (got < n_exp) begin
            int exp_beat = (e_code[got] << 15) | (e_nb[got] << 11) | e_bits[got];
            chk(beat == exp_beat, tag_of(got, e_code[got]), "beat {code,nbits,bits}", beat, exp_beat);
          end
          got++;
          if (got == n_exp) pend_done = 1;
        end else if (sym_valid) begin
          held = 1;
          held_val = beat;
        end
        @(negedge clk);
        it++;
      end
    end
    start = 1'b0;
    sym_ready = 1'b0;
    chk(got == n_exp, "R7", "beat count", got, n_exp);
    chk(done_seen, "R9", "done seen", done_seen, 1);
    chk(!stray, "R9", "no early done", stray, 0);
    if (time_chk) chk(first_it == 1, "R11", "cycles start to first beat", first_it + 1, 2);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    cyc = 0;
    void'($urandom(32'h2c0d_e5a1));
    build_zz();
    rst_n = 1'b0;
    coef_we = 1'b0;
    coef_addr = '0;
    coef_wdata = '0;
    start = 1'b0;
    sym_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R12
    chk(sym_valid == 1'b0, "R12", "valid in reset", sym_valid, 0);
    chk(done == 1'b0, "R12", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sym_valid == 1'b0 && done == 1'b0, "R12", "idle after reset", {sym_valid, done}, 0);

    // R1 R2 R4 R5 R6 R7: example block with long zero tail
    clear_blk();
    set_zz(0, 22); set_zz(1, 12); set_zz(3, 4); set_zz(6, -12);
    set_zz(7, -8); set_zz(53, 1);
    model();
    chk(n_exp == 9, "R6", "example symbol count", n_exp, 9);
    chk(e_code[3] == 8'h24 && e_bits[3] == 4'b0011, "R4", "model -12", e_bits[3], 3);
    run_block(0, 0, 1);

    // R7: all zeros gives DC then end-of-block
    clear_blk();
    run_block(0, 0, 1);

    // R7: last coefficient nonzero, no end-of-block; three extensions then E1
    clear_blk();
    set_zz(63, -1);
    run_block(30, 0, 0);

    // R3 R4: extreme magnitudes
    clear_blk();
    set_zz(0, -2047); set_zz(1, 2047); set_zz(2, -1024); set_zz(17, 1023);
    run_block(0, 0, 1);

    // R6: exactly sixteen zeros before a nonzero
    clear_blk();
    set_zz(0, 3); set_zz(17, -5); set_zz(18, 7);
    run_block(0, 0, 0);

    // R1 R10: dense block with restart attempt mid-block
    rand_blk(100);
    run_block(40, 1, 1);

    // R8: heavy stall
    rand_blk(30);
    run_block(80, 0, 0);

    for (int t = 0; t < 40; t++) begin
      rand_blk(($urandom % 4 == 0) ? 2 : 1 + ($urandom % 60));
      run_block($urandom % 60, 0, (t % 5 == 0));
    end

    summary_and_end();
  end

endmodule